// File: doc/BRIEF.md
# Quad-Input Page Program Receiver

This block is the device-side front end of a serial NOR flash that accepts page-program commands. A host drives a serial clock, an active-low chip select and four data lines. The block oversamples these lines with its own system clock. It shifts in an 8-bit opcode and a 24-bit address, then collects data bytes into a 256-byte page buffer.

When chip select rises on a legal boundary, the block checks three conditions: the write-enable latch is set, the target page is unprotected, and the command ended exactly after a whole data byte. If all three hold, a self-timed busy period starts. When the busy period ends, the buffered bytes are written into a small behavioural memory array. Only the bytes that were received are written.

The block also decodes a write-enable opcode, and a suspend and a resume opcode for a running program cycle. The status bits are presented directly on output pins. A read port lets the surrounding logic inspect the array.

Top module: `qpp_receiver`

## Requirements
- R1: After reset, `wip`, `wel` and `suspended` are 0 and every array byte reads 0xFF.
- R2: Opcode 0x06, sent as exactly 8 bits on dq[0] with chip select then released, sets `wel`.
- R3: Opcode 0x32 takes the opcode and the 24-bit address MSB first on dq[0], one bit per clock. Data then arrives two clocks per byte, high nibble first, with dq[3] carrying bit 7 (then bit 3). A legal release of chip select raises `wip` two system clocks after the release is seen, clears `wel` at that moment, and the array then holds the received bytes at address bits [7:0] upward in page address bits [9:8] (higher address bits ignored).
- R4: Bytes of the page that the command did not address keep their previous contents.
- R5: The buffer pointer wraps within the page on the low 8 address bits, so when more than 256 bytes arrive only the last 256 received are programmed.
- R6: If chip select rises anywhere other than right after a complete data byte (mid-byte, inside the opcode or address, or with no data byte at all), nothing is programmed, `wip` stays 0 and `wel` is unchanged.
- R7: A program command issued while `wel` is 0 is not executed.
- R8: A command to a protected page is not executed and leaves `wel` set. With protection level L (4 bits), L=0 protects nothing. Otherwise 2^(L-1) pages are protected, capped at the whole array, counted from page 0 when `protFromBottom` is 1 and from the highest page when it is 0.
- R9: Opcode 0x38 behaves like 0x32 except that the address arrives on all four lines, four bits per clock, dq[3] carrying the most significant bit of each nibble.
- R10: Opcode 0x75 during a busy cycle sets `suspended` and freezes the busy timer, with `wip` held at 1 and the array untouched. Opcode 0x7A clears `suspended` and the cycle then completes normally.
- R11: While `wip` is 1, every opcode other than 0x75 and 0x7A is ignored. In particular, write-enable and program commands change neither `wel`, the buffer nor the array.
- R12: `wip` stays 1 for exactly `CycleClocks` system clocks of unsuspended busy time, and it falls in the same clock that the array is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bus clock, data taken on its rising edge |
| csN | input | 1 | Active-low chip select |
| dq | input | 4 | Serial data lines |
| protLevel | input | 4 | Protection level L |
| protFromBottom | input | 1 | 1: protection counts up from page 0, 0: down from the top page |
| rdAddr | input | PageAddrW+8 | Array read address |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |
| suspended | output | 1 | Program cycle is suspended |
| rdData | output | 8 | Array byte at rdAddr |

## Verification
On every cycle, the assertions check the status relations. A program cycle can start only from a set write-enable latch, and that latch is clear once the cycle runs. The latch never rises during a busy cycle, a suspension only exists inside a busy cycle, and `wip` falls only right after the array commit. What lands in the array can only be shown by the bench's scenarios. These scenarios cover partial pages, the overflow wrap, the four-line address, dropped commands at each kind of misaligned release, protection at both ends of the array, and the cycle-exact busy length.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

  localparam int PageBytes = 256;
  localparam int PtrW      = $clog2(PageBytes);
  localparam int AddrW     = 24;

  localparam logic [7:0] OpWren    = 8'h06;
  localparam logic [7:0] OpProg    = 8'h32;
  localparam logic [7:0] OpProgX   = 8'h38;
  localparam logic [7:0] OpSuspend = 8'h75;
  localparam logic [7:0] OpResume  = 8'h7A;

  typedef enum logic [2:0] {
    SInstr, SAddr, SData, SDone, SIgnore
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearBuf;
    logic             loadPtr;
    logic             wrByte;
    logic             commit;
    logic [AddrW-1:0] addr;
    logic [7:0]       dat;
  } dpStrobe_t;

  function automatic logic pageLocked(input logic [3:0] level, input logic fromBottom,
                                      input int page, input int pageAddrW);
    int span;
    int total;
    if (level == 4'd0) return 1'b0;
    if (int'(level) - 1 >= pageAddrW) return 1'b1;
    span  = 1 << (int'(level) - 1);
    total = 1 << pageAddrW;
    return fromBottom ? (page < span) : (page >= total - span);
  endfunction

endpackage

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int PageAddrW   = 2,
  parameter int CycleClocks = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic [3:0] dq,
  input  logic [3:0] protLevel,
  input  logic       protFromBottom,
  output dpStrobe_t  stb,
  output logic       wip,
  output logic       wel,
  output logic       suspended
);

  localparam int CntW = (CycleClocks > 1) ? $clog2(CycleClocks) : 1;

  logic sckD1, sckD2, csD1, csD2;
  logic [3:0] dqD1;
  logic sckRise, csRise;

  busState_t state;
  logic [5:0]       bitCnt;
  logic [7:0]       instrSh, opReg;
  logic [AddrW-1:0] addrSh;
  logic             quadAddr;
  logic [3:0]       hiNib;
  logic             half, gotByte;
  logic             busy, welQ, suspQ;
  logic [CntW-1:0]  busyCnt;

  logic [7:0]       instrNext;
  logic [AddrW-1:0] addrNext;
  logic [5:0]       step;
  logic             addrDone, isProgNext, protHit, finishing;
  logic             startProg, wrenExec, suspExec, resExec;

  // bus synchronisation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD1 <= 1'b0; sckD2 <= 1'b0;
      csD1  <= 1'b1; csD2  <= 1'b1;
      dqD1  <= '0;
    end else begin
      sckD1 <= sck;  sckD2 <= sckD1;
      csD1  <= csN;  csD2  <= csD1;
      dqD1  <= dq;
    end
  end

  assign sckRise = sckD1 & ~sckD2 & ~csD1;
  assign csRise  = csD1 & ~csD2;

  assign instrNext  = {instrSh[6:0], dqD1[0]};
  assign addrNext   = quadAddr ? {addrSh[AddrW-5:0], dqD1} : {addrSh[AddrW-2:0], dqD1[0]};
  assign step       = quadAddr ? 6'd4 : 6'd1;
  assign addrDone   = (bitCnt + step) == 6'(AddrW);
  assign isProgNext = (instrNext == OpProg) || (instrNext == OpProgX);
  assign protHit    = pageLocked(protLevel, protFromBottom,
                                 int'(addrSh[PtrW +: PageAddrW]), PageAddrW);
  assign finishing  = busy & ~suspQ & (busyCnt == '0);

  assign startProg = csRise & (state == SData) & ~half & gotByte & ~busy & welQ & ~protHit
                     & ((opReg == OpProg) || (opReg == OpProgX));
  assign wrenExec  = csRise & (state == SDone) & (opReg == OpWren) & ~busy;
  assign suspExec  = csRise & (state == SDone) & (opReg == OpSuspend) & busy & ~suspQ & ~finishing;
  assign resExec   = csRise & (state == SDone) & (opReg == OpResume) & suspQ;

  always_comb begin
    stb          = '0;
    stb.clearBuf = sckRise & (state == SInstr) & (bitCnt == 6'd7) & ~busy & isProgNext;
    stb.loadPtr  = sckRise & (state == SAddr) & addrDone;
    stb.addr     = addrNext;
    stb.wrByte   = sckRise & (state == SData) & half;
    stb.dat      = {hiNib, dqD1};
    stb.commit   = finishing;
  end

  // serial command sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SInstr;
      bitCnt   <= '0;
      instrSh  <= '0;
      opReg    <= '0;
      addrSh   <= '0;
      quadAddr <= 1'b0;
      hiNib    <= '0;
      half     <= 1'b0;
      gotByte  <= 1'b0;
    end else if (csD1) begin
      state   <= SInstr;
      bitCnt  <= '0;
      half    <= 1'b0;
      gotByte <= 1'b0;
    end else if (sckRise) begin
      case (state)
        SInstr: begin
          instrSh <= instrNext;
          bitCnt  <= bitCnt + 6'd1;
          if (bitCnt == 6'd7) begin
            opReg  <= instrNext;
            bitCnt <= '0;
            if (busy)
              state <= ((instrNext == OpSuspend) || (instrNext == OpResume)) ? SDone : SIgnore;
            else if (isProgNext) begin
              state    <= SAddr;
              quadAddr <= (instrNext == OpProgX);
            end else if ((instrNext == OpWren) || (instrNext == OpSuspend) ||
                         (instrNext == OpResume))
              state <= SDone;
            else
              state <= SIgnore;
          end
        end
        SAddr: begin
          addrSh <= addrNext;
          bitCnt <= bitCnt + step;
          if (addrDone) state <= SData;
        end
        SData: begin
          if (!half) begin
            hiNib <= dqD1;
            half  <= 1'b1;
          end else begin
            half    <= 1'b0;
            gotByte <= 1'b1;
          end
        end
        SDone:   state <= SIgnore;
        default: ;
      endcase
    end
  end

  // status and busy timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
      welQ    <= 1'b0;
      suspQ   <= 1'b0;
    end else begin
      if (finishing)
        busy <= 1'b0;
      else if (busy && !suspQ)
        busyCnt <= busyCnt - 1'b1;
      if (startProg) begin
        busy    <= 1'b1;
        busyCnt <= CntW'(CycleClocks - 1);
        welQ    <= 1'b0;
      end
      if (wrenExec) welQ  <= 1'b1;
      if (suspExec) suspQ <= 1'b1;
      if (resExec)  suspQ <= 1'b0;
    end
  end

  assign wip       = busy;
  assign wel       = welQ;
  assign suspended = suspQ;

endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int PageAddrW = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  input  logic [PageAddrW+PtrW-1:0] rdAddr,
  output logic [7:0]            rdData
);

  localparam int ArrW     = PageAddrW + PtrW;
  localparam int ArrBytes = PageBytes << PageAddrW;

  logic [7:0]           pageBuf [PageBytes];
  logic [PageBytes-1:0] fillMask;
  logic [PtrW-1:0]      wrPtr;
  logic [PageAddrW-1:0] pageSel;
  logic [7:0]           mem [ArrBytes];
  logic                 unusedAddrBits;

  assign unusedAddrBits = ^stb.addr[AddrW-1:ArrW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillMask <= '0;
      wrPtr    <= '0;
      pageSel  <= '0;
    end else begin
      if (stb.clearBuf) fillMask <= '0;
      if (stb.loadPtr) begin
        wrPtr   <= stb.addr[PtrW-1:0];
        pageSel <= stb.addr[PtrW +: PageAddrW];
      end
      if (stb.wrByte) begin
        fillMask[wrPtr] <= 1'b1;
        wrPtr           <= wrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte) pageBuf[wrPtr] <= stb.dat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ArrBytes; i++) mem[i] <= 8'hFF;
    end else if (stb.commit) begin
      for (int i = 0; i < PageBytes; i++)
        if (fillMask[i]) mem[{pageSel, PtrW'(i)}] <= pageBuf[i];
    end
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/qpp_receiver.sv
module qpp_receiver
  import qpp_pkg::*;
#(
  parameter int PageAddrW   = 2,
  parameter int CycleClocks = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sck,
  input  logic                 csN,
  input  logic [3:0]           dq,
  input  logic [3:0]           protLevel,
  input  logic                 protFromBottom,
  input  logic [PageAddrW+7:0] rdAddr,
  output logic                 wip,
  output logic                 wel,
  output logic                 suspended,
  output logic [7:0]           rdData
);

  dpStrobe_t stb;

  qpp_ctrl #(.PageAddrW(PageAddrW), .CycleClocks(CycleClocks)) ctrlInst (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .dq(dq),
    .protLevel(protLevel), .protFromBottom(protFromBottom),
    .stb(stb), .wip(wip), .wel(wel), .suspended(suspended)
  );

  qpp_datapath #(.PageAddrW(PageAddrW)) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/qpp_checker.sv
module qpp_checker (
  input logic clk,
  input logic rstN,
  input logic wip,
  input logic wel,
  input logic susp,
  input logic commit
);

  assert_start_needs_wel_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));

  assert_wel_cleared_on_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> !wel);

  assert_no_wren_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !wip);

  assert_suspend_inside_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    susp |-> wip);

  assert_wip_falls_on_commit_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> $past(commit));

endmodule

bind qpp_receiver qpp_checker chk (
  .clk(clk), .rstN(rstN), .wip(wip), .wel(wel), .susp(suspended), .commit(stb.commit)
);

// File: tb/qpp_receiver_test.sv
module qpp_receiver_test;

  localparam int PAW = 2;
  localparam int CYC = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic [3:0] dq = '0;
  logic [3:0] protLevel = '0;
  logic protFromBottom = 1'b0;
  logic [PAW+7:0] rdAddr = '0;
  logic wip, wel, suspended;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] model [0:1023];

  always #5 clk = ~clk;

  qpp_receiver #(.PageAddrW(PAW), .CycleClocks(CYC)) uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .dq(dq),
    .protLevel(protLevel), .protFromBottom(protFromBottom), .rdAddr(rdAddr),
    .wip(wip), .wel(wel), .suspended(suspended), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dByte(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 3) & 255);
  endfunction

  task automatic modelApply(input logic [23:0] addr, input int n, input int seed);
    for (int k = 0; k < n; k++)
      model[((int'(addr) >> 8) & 3) * 256 + ((int'(addr) + k) & 255)] = dByte(seed, k);
  endtask

  task automatic checkPage(input int page, input string req);
    int errs = 0;
    int firstAct = 0;
    int firstExp = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rdAddr = (PAW+8)'(page * 256 + i);
      #1;
      if (rdData !== model[page * 256 + i]) begin
        if (errs == 0) begin firstAct = int'(rdData); firstExp = int'(model[page * 256 + i]); end
        errs++;
      end
    end
    check(errs == 0, req, $sformatf("page %0d contents (first bad byte)", page), firstAct, firstExp);
  endtask

  task automatic sendNib(input logic [3:0] n);
    @(negedge clk); dq = n;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sendByte1(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendNib({3'b000, b[i]});
  endtask

  task automatic sendByteQ(input logic [7:0] b);
    sendNib(b[7:4]);
    sendNib(b[3:0]);
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (2) @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic endCmd();
    csHigh();
    repeat (5) @(negedge clk);
  endtask

  task automatic simpleCmd(input logic [7:0] op);
    csLow(); sendByte1(op); endCmd();
  endtask

  task automatic progHeader(input logic [7:0] op, input logic [23:0] addr);
    csLow();
    sendByte1(op);
    if (op == 8'h38) for (int i = 5; i >= 0; i--) sendNib(addr[i*4 +: 4]);
    else for (int i = 23; i >= 0; i--) sendNib({3'b000, addr[i]});
  endtask

  task automatic sendData(input int n, input int seed);
    for (int k = 0; k < n; k++) sendByteQ(dByte(seed, k));
  endtask

  // releases chip select and follows the busy cycle to its end
  task automatic releaseAndRun(input string req);
    int lead = 0;
    int hi = 0;
    csHigh();
    while (lead < 8) begin
      @(negedge clk); lead++;
      if (wip) break;
    end
    check(wip == 1'b1 && lead == 2, req, "wip rise delay", lead, 2);
    check(wel == 1'b0, "R3", "wel cleared when cycle starts", int'(wel), 0);
    hi = 1;
    while (hi < 100000) begin
      @(negedge clk);
      if (!wip) break;
      hi++;
    end
    check(hi == CYC, "R12", "busy length in clocks", hi, CYC);
  endtask

  task automatic t_reset();
    check(wip == 0 && wel == 0 && suspended == 0, "R1", "status after reset",
          int'({wip, wel, suspended}), 0);
    checkPage(0, "R1");
  endtask

  task automatic t_wren();
    simpleCmd(8'h06);
    check(wel == 1'b1, "R2", "wel after write enable", int'(wel), 1);
  endtask

  task automatic t_basic();
    progHeader(8'h32, 24'hFC0110);
    sendData(5, 1);
    releaseAndRun("R3");
    modelApply(24'h000110, 5, 1);
    checkPage(1, "R3");
    simpleCmd(8'h06);
    progHeader(8'h32, 24'h000112);
    sendData(3, 2);
    releaseAndRun("R4");
    modelApply(24'h000112, 3, 2);
    checkPage(1, "R4");
  endtask

  task automatic t_overflow();
    simpleCmd(8'h06);
    progHeader(8'h32, 24'h0002F0);
    sendData(300, 3);
    releaseAndRun("R5");
    modelApply(24'h0002F0, 300, 3);
    checkPage(2, "R5");
  endtask

  task automatic t_drop();
    simpleCmd(8'h06);
    progHeader(8'h32, 24'h000020);
    sendData(3, 4);
    sendNib(4'hA);
    endCmd();
    check(wip == 0 && wel == 1, "R6", "mid-byte release dropped", int'({wip, wel}), 1);
    csLow();
    sendByte1(8'h32);
    for (int i = 0; i < 12; i++) sendNib(4'h0);
    endCmd();
    check(wip == 0 && wel == 1, "R6", "release inside address dropped", int'({wip, wel}), 1);
    progHeader(8'h32, 24'h000030);
    endCmd();
    check(wip == 0 && wel == 1, "R6", "release with no data dropped", int'({wip, wel}), 1);
    csLow();
    sendNib(4'h0); sendNib(4'h0);
    endCmd();
    check(wip == 0 && wel == 1, "R6", "release inside opcode dropped", int'({wip, wel}), 1);
    checkPage(0, "R6");
  endtask

  task automatic t_nowel();
    progHeader(8'h32, 24'h000001);
    sendData(1, 5);
    releaseAndRun("R7");
    modelApply(24'h000001, 1, 5);
    progHeader(8'h32, 24'h000080);
    sendData(4, 6);
    endCmd();
    check(wip == 0 && wel == 0, "R7", "program without wel ignored", int'({wip, wel}), 0);
    checkPage(0, "R7");
  endtask

  task automatic t_protect();
    protLevel = 4'd1; protFromBottom = 1'b1;
    simpleCmd(8'h06);
    progHeader(8'h32, 24'h000040);
    sendData(2, 7);
    endCmd();
    check(wip == 0 && wel == 1, "R8", "bottom page 0 locked", int'({wip, wel}), 1);
    protFromBottom = 1'b0;
    progHeader(8'h32, 24'h000340);
    sendData(2, 7);
    endCmd();
    check(wip == 0 && wel == 1, "R8", "top page 3 locked", int'({wip, wel}), 1);
    protLevel = 4'd2;
    progHeader(8'h32, 24'h000240);
    sendData(2, 7);
    endCmd();
    check(wip == 0 && wel == 1, "R8", "level 2 locks page 2", int'({wip, wel}), 1);
    progHeader(8'h32, 24'h000040);
    sendData(2, 8);
    releaseAndRun("R8");
    modelApply(24'h000040, 2, 8);
    checkPage(0, "R8");
    checkPage(2, "R8");
    checkPage(3, "R8");
    protLevel = 4'd0;
  endtask

  task automatic t_extended();
    simpleCmd(8'h06);
    progHeader(8'h38, 24'h0003A0);
    sendData(6, 9);
    releaseAndRun("R9");
    modelApply(24'h0003A0, 6, 9);
    checkPage(3, "R9");
  endtask

  task automatic t_suspend();
    int lead = 0;
    simpleCmd(8'h06);
    progHeader(8'h32, 24'h000140);
    sendData(8, 10);
    csHigh();
    while (lead < 8 && !wip) begin @(negedge clk); lead++; end
    simpleCmd(8'h06);
    check(wel == 0, "R11", "write enable ignored while busy", int'(wel), 0);
    progHeader(8'h32, 24'h000200);
    sendData(4, 11);
    endCmd();
    simpleCmd(8'h75);
    check(suspended == 1 && wip == 1, "R10", "suspend taken", int'({wip, suspended}), 3);
    repeat (2 * CYC) @(negedge clk);
    check(wip == 1, "R10", "wip held while suspended", int'(wip), 1);
    rdAddr = 10'h140; #1;
    check(rdData == 8'hFF, "R10", "array untouched while suspended", int'(rdData), 8'hFF);
    simpleCmd(8'h7A);
    check(suspended == 0 && wip == 1, "R10", "resume taken", int'({wip, suspended}), 2);
    lead = 0;
    while (wip && lead < 5000) begin @(negedge clk); lead++; end
    check(wip == 0, "R10", "cycle completes after resume", int'(wip), 0);
    modelApply(24'h000140, 8, 10);
    checkPage(1, "R10");
    checkPage(2, "R11");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wren();
    t_basic();
    t_overflow();
    t_drop();
    t_nowel();
    t_protect();
    t_extended();
    t_suspend();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule